// File: doc/BRIEF.md
# LCD Phase-Multiplexed Segment Sequencer

This block sequences a multiplexed LCD with up to eight backplane phases, A through H. Every LCD pin carries three settings: an enable bit, a backplane-select bit and an eight-bit waveform byte. The waveform byte has one bit per phase. A phase counter moves forward on a single-cycle tick input. For the phase that is current, the block gives each pin a logical state: an active backplane, a lit segment, or neither. Voltage generation, bias, clock division and blinking are handled elsewhere. The outputs here are logical per-phase states only.

Software selects a duty from one to eight phases and one of three display modes: normal, alternate or blank. Alternate mode runs short sequences from the upper half of each waveform byte instead of the lower half. This lets a byte hold two complete frames. Duty, alternate and blank settings are captured only at a frame boundary, so a single frame never mixes two configurations.

Top module: `lcdmux_sequencer`

## Requirements
- R1: After reset the sequencer is at sequence step 0 with physical phase 0 (A) on `phase_id`, `phase_strobe` is low, and the captured configuration is one phase in normal mode, whatever the mode and duty inputs show.
- R2: A high `phase_tick` at a clock edge moves the sequence one step on and raises `phase_strobe` for exactly the following cycle. Without a tick, the step holds and `phase_strobe` stays low.
- R3: `duty_sel` encodes the phase count as value+1 (0 means 1 phase, 7 means 8 phases). After the last step of the captured count, the next tick returns the sequence to step 0.
- R4: `duty_sel`, `alt_mode` and `blank_mode` are captured only on the tick that wraps the sequence to step 0. Changes between those ticks do not affect the frame in progress.
- R5: An enabled pin with its select bit set is a backplane. `bp_active[i]` equals bit p of its waveform byte, where p is the physical phase and bit 0 is phase A. Its `fp_on[i]` is 0. Pin i's byte is `wave_data[8*i+7:8*i]`.
- R6: An enabled pin with its select bit clear is a frontplane. `fp_on[i]` equals bit p of its waveform byte, and its `bp_active[i]` is 0.
- R7: A pin whose enable bit is clear shows 0 on both `bp_active` and `fp_on` in every phase and mode.
- R8: With blank captured, all `bp_active` and `fp_on` bits are 0 and the waveform data is ignored. The sequence still steps, with `phase_id` equal to the step. Blank takes priority over alternate.
- R9: With alternate captured, blank clear and duty of four phases or fewer, the physical phase is the step plus 4 (E, F, G, H in place of A, B, C, D).
- R10: With alternate captured and duty of five phases or more, the display is blanked as in R8, with no remapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_tick | input | 1 | Single-cycle request to advance to the next phase |
| duty_sel | input | 3 | Phase count minus one |
| alt_mode | input | 1 | Alternate display request |
| blank_mode | input | 1 | Blank display request |
| pin_en | input | NUM_PINS | Per-pin enable |
| pin_bp | input | NUM_PINS | Per-pin backplane select |
| wave_data | input | 8*NUM_PINS | Waveform bytes, pin i in bits 8i+7..8i |
| phase_strobe | output | 1 | Marks the first cycle of each new phase |
| phase_id | output | 3 | Physical phase now driven (0 = A) |
| bp_active | output | NUM_PINS | Backplane active per pin |
| fp_on | output | NUM_PINS | Segment on per pin |

## Verification
The bench changes duty and mode in the middle of a frame. A design that applied the change at once would break the old frame early or jump into the upper phases too soon. It sweeps every duty, so a wrap one step off in either direction shows up as a wrong `phase_id`. Alternate mode is exercised at both one phase and four phases, where a design that failed to remap would show lower-half bits. It is also exercised at five and eight phases, where a design that still remapped, or drove segments, would light pins that must stay dark. Blank combined with alternate, and disabled pins that carry set waveform bits, check that nothing leaks through to the outputs.

// File: rtl/lcdmux_pkg.sv
package lcdmux_pkg;
  localparam int PHASES  = 8;
  localparam int PHASE_W = $clog2(PHASES);

  typedef enum logic [1:0] {
    DISP_NORMAL = 2'd0,
    DISP_ALT    = 2'd1,
    DISP_BLANK  = 2'd2
  } disp_t;

  // Resolve the requested mode bits against the duty code.
  function automatic disp_t resolve_mode(input logic alt, input logic blank,
                                         input logic [PHASE_W-1:0] duty_code);
    if (blank) return DISP_BLANK;
    if (alt) return (duty_code > PHASE_W'(PHASES/2 - 1)) ? DISP_BLANK : DISP_ALT;
    return DISP_NORMAL;
  endfunction

  // Map a sequence step onto the physical phase that is driven.
  function automatic logic [PHASE_W-1:0] map_phase(input disp_t m,
                                                   input logic [PHASE_W-1:0] step);
    if (m == DISP_ALT) return step + PHASE_W'(PHASES/2);
    return step;
  endfunction
endpackage

// File: rtl/lcdmux_phase_ctrl.sv
module lcdmux_phase_ctrl
  import lcdmux_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               phase_tick,
  input  logic [PHASE_W-1:0] duty_sel,
  input  logic               alt_mode,
  input  logic               blank_mode,
  output logic [PHASE_W-1:0] step,
  output disp_t              frame_mode,
  output logic               phase_strobe
);
  logic [PHASE_W-1:0] step_q, duty_q;
  disp_t              mode_q;
  logic               strobe_q;
  logic               last_step;
  logic               frame_wrap;

  assign last_step  = (step_q == duty_q);
  assign frame_wrap = phase_tick && last_step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q   <= '0;
      duty_q   <= '0;
      mode_q   <= DISP_NORMAL;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= phase_tick;
      if (frame_wrap) begin
        step_q <= '0;
        duty_q <= duty_sel;
        mode_q <= resolve_mode(alt_mode, blank_mode, duty_sel);
      end else if (phase_tick) begin
        step_q <= step_q + PHASE_W'(1);
      end
    end
  end

  assign step         = step_q;
  assign frame_mode   = mode_q;
  assign phase_strobe = strobe_q;

  p_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    phase_tick |=> phase_strobe);
  p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_tick |=> !phase_strobe && $stable(step_q));
  p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_tick && !last_step) |=> step_q == $past(step_q) + PHASE_W'(1));
  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_wrap |=> step_q == '0);
  p_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step_q <= duty_q);
  p_cfg_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_wrap |=> $stable(duty_q) && $stable(mode_q));
  p_alt_short_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q == DISP_ALT |-> duty_q < PHASE_W'(PHASES/2));
endmodule

// File: rtl/lcdmux_pin_decode.sv
module lcdmux_pin_decode
  import lcdmux_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               is_bp,
  input  logic [PHASES-1:0]  wave,
  input  logic [PHASE_W-1:0] phase,
  input  logic               dark,
  output logic               bp_on,
  output logic               seg_on
);
  logic live_bit;

  assign live_bit = en && !dark && wave[phase];
  assign bp_on    = live_bit && is_bp;
  assign seg_on   = live_bit && !is_bp;

  p_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(bp_on && seg_on));
  p_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !bp_on && !seg_on);
endmodule

// File: rtl/lcdmux_sequencer.sv
module lcdmux_sequencer
  import lcdmux_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       phase_tick,
  input  logic [PHASE_W-1:0]         duty_sel,
  input  logic                       alt_mode,
  input  logic                       blank_mode,
  input  logic [NUM_PINS-1:0]        pin_en,
  input  logic [NUM_PINS-1:0]        pin_bp,
  input  logic [PHASES*NUM_PINS-1:0] wave_data,
  output logic                       phase_strobe,
  output logic [PHASE_W-1:0]         phase_id,
  output logic [NUM_PINS-1:0]        bp_active,
  output logic [NUM_PINS-1:0]        fp_on
);
  logic [PHASE_W-1:0] step;
  disp_t              frame_mode;
  logic               dark;

  lcdmux_phase_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .phase_tick   (phase_tick),
    .duty_sel     (duty_sel),
    .alt_mode     (alt_mode),
    .blank_mode   (blank_mode),
    .step         (step),
    .frame_mode   (frame_mode),
    .phase_strobe (phase_strobe)
  );

  assign dark     = (frame_mode == DISP_BLANK);
  assign phase_id = map_phase(frame_mode, step);

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    lcdmux_pin_decode u_pin (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (pin_en[i]),
      .is_bp  (pin_bp[i]),
      .wave   (wave_data[i*PHASES +: PHASES]),
      .phase  (phase_id),
      .dark   (dark),
      .bp_on  (bp_active[i]),
      .seg_on (fp_on[i])
    );
  end

  p_blank_dark_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dark |-> (bp_active == '0) && (fp_on == '0) && (phase_id == step));
  p_alt_upper_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_mode == DISP_ALT |-> phase_id[PHASE_W-1]);
endmodule

// File: tb/lcdmux_sequencer_tb.sv
module lcdmux_sequencer_tb;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         phase_tick = 1'b0;
  logic [2:0]   duty_sel = '0;
  logic         alt_mode = 1'b0;
  logic         blank_mode = 1'b0;
  logic [N-1:0] pin_en = '0;
  logic [N-1:0] pin_bp = '0;
  logic [8*N-1:0] wave_data = '0;
  logic         phase_strobe;
  logic [2:0]   phase_id;
  logic [N-1:0] bp_active, fp_on;

  int checks = 0, failures = 0;
  bit done = 0;
  // Bench model of the sequence
  int mstep = 0, mduty = 0;
  bit malt = 0, mblank = 0;

  always #2 clk = ~clk;

  lcdmux_sequencer #(.NUM_PINS(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .phase_tick(phase_tick), .duty_sel(duty_sel),
    .alt_mode(alt_mode), .blank_mode(blank_mode), .pin_en(pin_en),
    .pin_bp(pin_bp), .wave_data(wave_data), .phase_strobe(phase_strobe),
    .phase_id(phase_id), .bp_active(bp_active), .fp_on(fp_on));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_outputs(input string req, input bit strobe_exp);
    bit dark;
    bit alt_on;
    int ph;
    logic [N-1:0] ebp, efp;
    dark   = mblank || (malt && mduty >= 4);
    alt_on = malt && !mblank && mduty <= 3;
    ph     = alt_on ? mstep + 4 : mstep;
    ebp = '0;
    efp = '0;
    for (int i = 0; i < N; i++) begin
      if (pin_en[i] && !dark && wave_data[i*8 + ph]) begin
        if (pin_bp[i]) ebp[i] = 1'b1;
        else efp[i] = 1'b1;
      end
    end
    chk(req, "phase_id", int'(phase_id), ph);
    chk(req, "strobe", int'(phase_strobe), int'(strobe_exp));
    chk(req, "bp_active", int'(bp_active), int'(ebp));
    chk(req, "fp_on", int'(fp_on), int'(efp));
  endtask

  // One tick, driven and sampled on falling edges
  task automatic do_tick(input string req);
    phase_tick = 1'b1;
    @(negedge clk);
    phase_tick = 1'b0;
    if (mstep == mduty) begin
      mstep = 0;
      mduty = int'(duty_sel);
      malt = alt_mode;
      mblank = blank_mode;
    end else begin
      mstep++;
    end
    check_outputs(req, 1'b1);
  endtask

  task automatic sync_frame(input string req);
    while (mstep != mduty) do_tick(req);
    do_tick(req);
  endtask

  task automatic t_reset;
    alt_mode = 1'b1; duty_sel = 3'd3;
    pin_en = '1; pin_bp = 8'b0000_0011;
    wave_data = 64'hA5C3_0F96_5A3C_8118;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_outputs("R1", 1'b0);
    chk("R1", "reset phase A", int'(phase_id), 0);
    // First tick wraps a 1-phase frame and captures alt, 4 phases
    do_tick("R4");
    chk("R9", "alt starts at E", int'(phase_id), 4);
  endtask

  task automatic t_no_tick;
    logic [2:0] held;
    held = phase_id;
    repeat (4) @(negedge clk);
    chk("R2", "held phase", int'(phase_id), int'(held));
    check_outputs("R2", 1'b0);
  endtask

  task automatic t_normal;
    alt_mode = 1'b0; blank_mode = 1'b0; duty_sel = 3'd3;
    sync_frame("R3");
    for (int k = 0; k < 8; k++) do_tick("R5");
    wave_data = 64'h3C5A_F00F_9966_2481;
    for (int k = 0; k < 4; k++) do_tick("R6");
  endtask

  task automatic t_duty_sweep;
    for (int d = 0; d < 8; d++) begin
      duty_sel = 3'(d);
      sync_frame("R3");
      for (int k = 0; k < d + 2; k++) do_tick("R3");
    end
  endtask

  task automatic t_disabled;
    pin_en = 8'b0101_1110;
    wave_data = '1;
    duty_sel = 3'd7;
    sync_frame("R7");
    for (int k = 0; k < 8; k++) begin
      do_tick("R7");
      chk("R7", "disabled pins dark", int'(bp_active[0] | fp_on[0] | bp_active[5] | fp_on[5]), 0);
    end
    pin_en = '1;
    wave_data = 64'h1234_5678_9ABC_DEF0;
  endtask

  task automatic t_blank;
    blank_mode = 1'b1; alt_mode = 1'b1; duty_sel = 3'd2;
    sync_frame("R8");
    for (int k = 0; k < 5; k++) begin
      do_tick("R8");
      chk("R8", "blank outputs", int'(bp_active | fp_on), 0);
    end
    blank_mode = 1'b0; alt_mode = 1'b0;
  endtask

  task automatic t_alt_low;
    alt_mode = 1'b1;
    wave_data = 64'hF0E1_D2C3_B4A5_9687;
    duty_sel = 3'd0;
    sync_frame("R9");
    do_tick("R9");
    chk("R9", "1/1 alt phase", int'(phase_id), 4);
    duty_sel = 3'd1;
    sync_frame("R9");
    for (int k = 0; k < 4; k++) do_tick("R9");
    duty_sel = 3'd3;
    sync_frame("R9");
    for (int k = 0; k < 4; k++) do_tick("R9");
  endtask

  task automatic t_alt_high;
    alt_mode = 1'b1; wave_data = '1;
    duty_sel = 3'd4;
    sync_frame("R10");
    for (int k = 0; k < 5; k++) begin
      do_tick("R10");
      chk("R10", "alt 1/5 dark", int'(bp_active | fp_on), 0);
    end
    duty_sel = 3'd7;
    sync_frame("R10");
    for (int k = 0; k < 8; k++) do_tick("R10");
    alt_mode = 1'b0;
    wave_data = 64'h0123_4567_89AB_CDEF;
  endtask

  task automatic t_midframe;
    alt_mode = 1'b0; blank_mode = 1'b0; duty_sel = 3'd3;
    sync_frame("R4");
    do_tick("R4");
    // Change mid-frame: must not touch the frame in progress
    duty_sel = 3'd1; alt_mode = 1'b1;
    do_tick("R4");
    chk("R4", "old frame step 2", int'(phase_id), 2);
    do_tick("R4");
    chk("R4", "old frame step 3", int'(phase_id), 3);
    do_tick("R4");
    chk("R4", "new frame alt E", int'(phase_id), 4);
    do_tick("R4");
    chk("R4", "new frame alt F", int'(phase_id), 5);
    do_tick("R3");
    chk("R3", "2-phase wrap", int'(phase_id), 4);
  endtask

  initial begin
    @(negedge clk);
    t_reset;
    t_no_tick;
    t_normal;
    t_duty_sweep;
    t_disabled;
    t_blank;
    t_alt_low;
    t_alt_high;
    t_midframe;
    t_no_tick;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule